// File: doc/BRIEF.md
# Radio SPI Command Decoder

This block is the control-port slave of a small packet radio. A host talks to it over a four-wire SPI link (mode 0: SCK idles low, data sampled on the rising edge, MSB first). The first byte after chip select goes low is a command. It holds an operation code, and some opcodes also carry a register address or a pipe number. The bytes that follow go to a 32-entry byte register bank, to a receive payload queue, or to a transmit payload queue. Some commands act at once: the queue flushes, the reuse marker and the no-operation command.

The radio side sits outside this block. It pushes received bytes into the receive queue and drains the transmit queue through plain strobe ports. It raises the data-ready, data-sent and retry-limit flags with single-cycle pulses. The host clears those flags by writing ones to the status register.

All SPI pins are sampled in the system clock domain. SCK must therefore be slow compared with the system clock: each SCK half period must be at least four system clocks.

Top module: `rspi_cmd_decoder`

## Requirements
- R1: While the command byte shifts in, MISO returns the status word MSB first. Its bits are: 6 data-ready, 5 data-sent, 4 retry-limit, 3:1 pipe number (7 when the receive queue is empty, else 0), 0 transmit-queue full, and bit 7 reads 0. Register address 0x07 reads the same word.
- R2: Command 0x00|a (a in 0..31) reads register a, and command 0x20|a writes it. Each further data byte moves to address a+1, wrapping from 31 to 0.
- R3: A write to address 0x07 clears each of the three flags (bits 6, 5, 4) whose data bit is one. A zero data bit leaves that flag as it is. A radio set pulse in the same cycle wins over the clear.
- R4: Address 0x17 reads the queue status: bit 0 receive empty, bit 1 receive full, bit 4 transmit empty, bit 5 transmit full, bit 6 reuse marker, all other bits 0. Writes to 0x17 have no effect.
- R5: Command 0x61 returns bytes from the receive queue in arrival order, one per data byte. A data byte clocked while the queue is empty returns 0x00 and leaves the queue as it is. The queue holds 8 bytes, and pushes while it is full are dropped.
- R6: Command 0xA0, and command 0xA8|p (p in 0..7), append each data byte to the transmit queue. The radio side reads the queue in order at `tx_head`. The queue holds 8 bytes, and bytes sent while it is full are dropped.
- R7: Command 0xE1 empties the transmit queue and command 0xE2 empties the receive queue, both when the command byte completes.
- R8: Command 0xE3 sets the reuse marker. Command 0xE1 or command 0xA0 clears it.
- R9: Command 0x60 returns, in its data byte, the payload width (4) when the receive queue holds data, and 0 when it is empty.
- R10: Command 0x50 followed by code 0x73 toggles `feat_en`. Any other code leaves it unchanged.
- R11: Chip select going high ends a transaction. A partly shifted byte is discarded and has no effect.
- R12: `irq_n` is low exactly while at least one of the three status flags is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| spi_csn | input | 1 | SPI chip select, active low |
| spi_sck | input | 1 | SPI clock, mode 0 |
| spi_mosi | input | 1 | Host to block serial data |
| spi_miso | output | 1 | Block to host serial data (0 when not selected) |
| rx_push | input | 1 | Radio side: append `rx_push_data` to the receive queue |
| rx_push_data | input | 8 | Received byte |
| rx_pkt_stb | input | 1 | Radio side: set the data-ready flag |
| tx_pop | input | 1 | Radio side: remove the head of the transmit queue |
| tx_head | output | 8 | Head byte of the transmit queue |
| tx_empty | output | 1 | Transmit queue is empty |
| tx_sent_stb | input | 1 | Radio side: set the data-sent flag |
| max_rt_stb | input | 1 | Radio side: set the retry-limit flag |
| irq_n | output | 1 | Active-low interrupt, any flag set |
| feat_en | output | 1 | Feature-enable bit toggled by the activate command |

## Verification
The bench targets these corner cases:

- Reading past the end of the receive queue. A design that pops on the byte it offers, instead of the byte it finished sending, loses the last payload byte or returns stale data where 0x00 is due.
- Clearing only some flags. One zero bit in a write-one-to-clear word must leave its flag alone. A plain register write would drop all three flags, and a wrong mask would leave `irq_n` low.
- Address wrap from 31 to 0 on a burst.
- Writes that must have no effect: to the queue-status address, an activate code other than 0x73, and a write command cut off mid-byte by chip select.
- Overflow of both queues. A design that overwrites when full shows the ninth byte in place of the first.

// File: rtl/rspi_pkg.sv
package rspi_pkg;

  localparam int BYTE_W      = 8;
  localparam int REG_AW      = 5;
  localparam int NREG        = 1 << REG_AW;
  localparam logic [REG_AW-1:0] STATUS_ADDR = 5'h07;
  localparam logic [REG_AW-1:0] QSTAT_ADDR  = 5'h17;
  localparam logic [BYTE_W-1:0] ACT_KEY     = 8'h73;

  // Flag positions inside the status word (host-visible, bit positions matter)
  localparam int BIT_RXDR  = 6;
  localparam int BIT_TXDS  = 5;
  localparam int BIT_MAXRT = 4;

  typedef enum logic [3:0] {
    OP_RREG, OP_WREG, OP_ACT, OP_PLWID, OP_RXRD, OP_TXWR,
    OP_ACKWR, OP_FLTX, OP_FLRX, OP_REUSE, OP_NOP, OP_BAD
  } op_e;

  typedef enum logic [2:0] {
    PH_CMD, PH_RREG, PH_WREG, PH_ACT, PH_WID, PH_RXRD, PH_TXWR, PH_SKIP
  } phase_e;

  function automatic op_e decode_op(input logic [BYTE_W-1:0] b);
    op_e r;
    casez (b)
      8'b000?_????: r = OP_RREG;
      8'b001?_????: r = OP_WREG;
      8'h50:        r = OP_ACT;
      8'h60:        r = OP_PLWID;
      8'h61:        r = OP_RXRD;
      8'hA0:        r = OP_TXWR;
      8'b1010_1???: r = OP_ACKWR;
      8'hE1:        r = OP_FLTX;
      8'hE2:        r = OP_FLRX;
      8'hE3:        r = OP_REUSE;
      8'hFF:        r = OP_NOP;
      default:      r = OP_BAD;
    endcase
    return r;
  endfunction

  function automatic logic [BYTE_W-1:0] status_word(
    input logic rx_dr, input logic tx_ds, input logic max_rt,
    input logic rx_empty, input logic tx_full);
    logic [2:0] pipe;
    pipe = rx_empty ? 3'b111 : 3'b000;
    return {1'b0, rx_dr, tx_ds, max_rt, pipe, tx_full};
  endfunction

  function automatic logic [BYTE_W-1:0] qstat_word(
    input logic reuse, input logic tx_full, input logic tx_empty,
    input logic rx_full, input logic rx_empty);
    return {1'b0, reuse, tx_full, tx_empty, 2'b00, rx_full, rx_empty};
  endfunction

  // Next value of a write-one-to-clear flag: a set pulse wins over a clear
  function automatic logic w1c_next(input logic cur, input logic set,
                                    input logic clr);
    return set | (cur & ~clr);
  endfunction

endpackage

// File: rtl/rspi_shifter.sv
module rspi_shifter
  import rspi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csn,
  input  logic              sck,
  input  logic              mosi,
  input  logic [BYTE_W-1:0] status_in,
  input  logic [BYTE_W-1:0] next_in,
  output logic              miso,
  output logic              cs_act,
  output logic              byte_done,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              load_stb
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic [2:0] csn_q, sck_q;
  logic [1:0] mosi_q;
  logic [CNT_W-1:0] bitcnt;
  logic [BYTE_W-1:0] shin, shout;
  logic cs_start, cs_end, sck_rise, sck_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csn_q  <= '1;
      sck_q  <= '0;
      mosi_q <= '0;
    end else begin
      csn_q  <= {csn_q[1:0], csn};
      sck_q  <= {sck_q[1:0], sck};
      mosi_q <= {mosi_q[0], mosi};
    end
  end

  assign cs_act   = ~csn_q[1];
  assign cs_start = csn_q[2] & ~csn_q[1];
  assign cs_end   = ~csn_q[2] & csn_q[1];
  assign sck_rise = cs_act & sck_q[1] & ~sck_q[2];
  assign sck_fall = cs_act & ~sck_q[1] & sck_q[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitcnt    <= '0;
      shin      <= '0;
      shout     <= '0;
      byte_done <= 1'b0;
      load_stb  <= 1'b0;
    end else if (cs_start) begin
      bitcnt    <= '0;
      shin      <= '0;
      shout     <= status_in;
      byte_done <= 1'b0;
      load_stb  <= 1'b0;
    end else if (!cs_act) begin
      bitcnt    <= '0;
      byte_done <= 1'b0;
      load_stb  <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      load_stb  <= 1'b0;
      if (sck_rise) begin
        shin   <= {shin[BYTE_W-2:0], mosi_q[1]};
        bitcnt <= bitcnt + 1'b1;
        if (bitcnt == CNT_W'(BYTE_W-1)) byte_done <= 1'b1;
      end
      if (sck_fall) begin
        if (bitcnt == '0) begin
          shout    <= next_in;
          load_stb <= 1'b1;
        end else begin
          shout <= {shout[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end

  assign rx_byte = shin;
  assign miso    = cs_act & shout[BYTE_W-1];

  AST_PARTIAL_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
    cs_end |=> (bitcnt == '0) && !byte_done);  // R11
  AST_DONE_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> !byte_done);  // R11

endmodule

// File: rtl/rspi_fifo.sv
module rspi_fifo
  import rspi_pkg::*;
#(
  parameter int AW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [BYTE_W-1:0] din,
  input  logic              pop,
  input  logic              flush,
  output logic [BYTE_W-1:0] dout,
  output logic              empty,
  output logic              full
);
  localparam int DEPTH = 1 << AW;

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [AW-1:0] rp, wp;
  logic [AW:0]   count;
  logic do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == (AW+1)'(DEPTH));
  assign do_push = push & ~full & ~flush;
  assign do_pop  = pop & ~empty & ~flush;
  assign dout    = empty ? '0 : mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp    <= '0;
      wp    <= '0;
      count <= '0;
    end else if (flush) begin
      rp    <= '0;
      wp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !flush) |=> full && (count == $past(count)));  // R6
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> empty);  // R5
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);  // R7

endmodule

// File: rtl/rspi_regs.sv
module rspi_regs
  import rspi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [REG_AW-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  input  logic              rx_set,
  input  logic              tx_set,
  input  logic              mrt_set,
  input  logic              rx_empty,
  input  logic              rx_full,
  input  logic              tx_empty,
  input  logic              tx_full,
  input  logic              reuse,
  output logic [BYTE_W-1:0] status,
  output logic              irq_n
);
  logic [NREG-1:0][BYTE_W-1:0] plain_q;
  logic rx_dr, tx_ds, max_rt;
  logic st_wr;

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_reg
      if (g == int'(STATUS_ADDR) || g == int'(QSTAT_ADDR)) begin : g_special
        assign plain_q[g] = '0;
      end else begin : g_plain
        logic [BYTE_W-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)                                q <= '0;
          else if (wr_en && wr_addr == REG_AW'(g))   q <= wr_data;
        end
        assign plain_q[g] = q;
      end
    end
  endgenerate

  assign st_wr = wr_en && (wr_addr == STATUS_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_dr  <= 1'b0;
      tx_ds  <= 1'b0;
      max_rt <= 1'b0;
    end else begin
      rx_dr  <= w1c_next(rx_dr,  rx_set,  st_wr & wr_data[BIT_RXDR]);
      tx_ds  <= w1c_next(tx_ds,  tx_set,  st_wr & wr_data[BIT_TXDS]);
      max_rt <= w1c_next(max_rt, mrt_set, st_wr & wr_data[BIT_MAXRT]);
    end
  end

  assign status = status_word(rx_dr, tx_ds, max_rt, rx_empty, tx_full);
  assign irq_n  = ~(rx_dr | tx_ds | max_rt);

  always_comb begin
    if (rd_addr == STATUS_ADDR)     rd_data = status;
    else if (rd_addr == QSTAT_ADDR) rd_data = qstat_word(reuse, tx_full, tx_empty, rx_full, rx_empty);
    else                            rd_data = plain_q[rd_addr];
  end

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && wr_data[BIT_RXDR] && !rx_set) |=> !rx_dr);  // R3
  AST_W1C_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ds && !(st_wr && wr_data[BIT_TXDS])) |=> tx_ds);  // R3
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    mrt_set |=> max_rt && !irq_n);  // R12

endmodule

// File: rtl/rspi_cmd_decoder.sv
module rspi_cmd_decoder
  import rspi_pkg::*;
#(
  parameter int PAYLOAD_W = 4,
  parameter int RX_AW     = 3,
  parameter int TX_AW     = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spi_csn,
  input  logic       spi_sck,
  input  logic       spi_mosi,
  output logic       spi_miso,
  input  logic       rx_push,
  input  logic [7:0] rx_push_data,
  input  logic       rx_pkt_stb,
  input  logic       tx_pop,
  output logic [7:0] tx_head,
  output logic       tx_empty,
  input  logic       tx_sent_stb,
  input  logic       max_rt_stb,
  output logic       irq_n,
  output logic       feat_en
);
  localparam logic [BYTE_W-1:0] WIDTH_BYTE = BYTE_W'(PAYLOAD_W);

  logic cs_act, byte_done, load_stb;
  logic [BYTE_W-1:0] rx_byte, status, rd_data, rx_head;
  logic rx_empty, rx_full, tx_full;

  phase_e phase;
  logic [REG_AW-1:0] addr;
  logic [BYTE_W-1:0] next_byte;
  logic next_fifo, sh_fifo, prep_q, reuse;
  op_e cmd_op;

  // Named internal events
  logic in_cmd, in_data, wr_en, tx_push_w, tx_flush_w, rx_flush_w, rx_pop_w;

  assign cmd_op     = decode_op(rx_byte);
  assign in_cmd     = byte_done && (phase == PH_CMD);
  assign in_data    = byte_done && (phase != PH_CMD);
  assign wr_en      = in_data && (phase == PH_WREG);
  assign tx_push_w  = in_data && (phase == PH_TXWR);
  assign rx_pop_w   = in_data && (phase == PH_RXRD) && sh_fifo;
  assign tx_flush_w = in_cmd && (cmd_op == OP_FLTX);
  assign rx_flush_w = in_cmd && (cmd_op == OP_FLRX);

  rspi_shifter u_shift (
    .clk, .rst_n,
    .csn       (spi_csn),
    .sck       (spi_sck),
    .mosi      (spi_mosi),
    .status_in (status),
    .next_in   (next_byte),
    .miso      (spi_miso),
    .cs_act    (cs_act),
    .byte_done (byte_done),
    .rx_byte   (rx_byte),
    .load_stb  (load_stb)
  );

  rspi_fifo #(.AW(RX_AW)) u_rxq (
    .clk, .rst_n,
    .push  (rx_push),
    .din   (rx_push_data),
    .pop   (rx_pop_w),
    .flush (rx_flush_w),
    .dout  (rx_head),
    .empty (rx_empty),
    .full  (rx_full)
  );

  rspi_fifo #(.AW(TX_AW)) u_txq (
    .clk, .rst_n,
    .push  (tx_push_w),
    .din   (rx_byte),
    .pop   (tx_pop),
    .flush (tx_flush_w),
    .dout  (tx_head),
    .empty (tx_empty),
    .full  (tx_full)
  );

  rspi_regs u_regs (
    .clk, .rst_n,
    .wr_en    (wr_en),
    .wr_addr  (addr),
    .wr_data  (rx_byte),
    .rd_addr  (addr),
    .rd_data  (rd_data),
    .rx_set   (rx_pkt_stb),
    .tx_set   (tx_sent_stb),
    .mrt_set  (max_rt_stb),
    .rx_empty (rx_empty),
    .rx_full  (rx_full),
    .tx_empty (tx_empty),
    .tx_full  (tx_full),
    .reuse    (reuse),
    .status   (status),
    .irq_n    (irq_n)
  );

  // Transaction state: cleared whenever chip select is inactive
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_CMD;
      addr      <= '0;
      next_byte <= '0;
      next_fifo <= 1'b0;
      sh_fifo   <= 1'b0;
      prep_q    <= 1'b0;
    end else if (!cs_act) begin
      phase     <= PH_CMD;
      next_byte <= '0;
      next_fifo <= 1'b0;
      sh_fifo   <= 1'b0;
      prep_q    <= 1'b0;
    end else begin
      prep_q <= byte_done;
      if (load_stb) sh_fifo <= next_fifo;
      if (in_cmd) begin
        addr <= rx_byte[REG_AW-1:0];
        case (cmd_op)
          OP_RREG:           phase <= PH_RREG;
          OP_WREG:           phase <= PH_WREG;
          OP_ACT:            phase <= PH_ACT;
          OP_PLWID:          phase <= PH_WID;
          OP_RXRD:           phase <= PH_RXRD;
          OP_TXWR, OP_ACKWR: phase <= PH_TXWR;
          default:           phase <= PH_SKIP;
        endcase
      end
      if (in_data) begin
        case (phase)
          PH_RREG, PH_WREG: addr <= addr + 1'b1;
          PH_ACT, PH_WID:   phase <= PH_SKIP;
          default:          ;
        endcase
      end
      // One cycle after a byte completes, prepare the byte shifted out next
      if (prep_q) begin
        case (phase)
          PH_RREG: begin next_byte <= rd_data; next_fifo <= 1'b0; end
          PH_WID:  begin next_byte <= rx_empty ? '0 : WIDTH_BYTE; next_fifo <= 1'b0; end
          PH_RXRD: begin next_byte <= rx_head; next_fifo <= ~rx_empty; end
          default: begin next_byte <= '0; next_fifo <= 1'b0; end
        endcase
      end
    end
  end

  // Persistent command effects
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reuse   <= 1'b0;
      feat_en <= 1'b0;
    end else begin
      if (in_cmd && cmd_op == OP_REUSE)                          reuse <= 1'b1;
      else if (in_cmd && (cmd_op == OP_FLTX || cmd_op == OP_TXWR)) reuse <= 1'b0;
      if (in_data && phase == PH_ACT && rx_byte == ACT_KEY)      feat_en <= ~feat_en;
    end
  end

  AST_SKIP_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SKIP) |-> !tx_push_w && !rx_pop_w && !wr_en);  // R7
  AST_TX_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush_w |=> tx_empty);  // R7
  AST_REUSE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (in_cmd && cmd_op == OP_REUSE) |=> reuse);  // R8
  AST_POP_ONLY_FIFO_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop_w |-> !rx_empty);  // R5
  AST_FEAT_ONLY_ON_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_data && phase == PH_ACT) |=> $stable(feat_en));  // R10

endmodule

// File: tb/rspi_cmd_decoder_tb.sv
module rspi_cmd_decoder_tb;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_csn = 1'b1, spi_sck = 1'b0, spi_mosi = 1'b0;
  logic spi_miso;
  logic rx_push = 1'b0, rx_pkt_stb = 1'b0, tx_pop = 1'b0;
  logic tx_sent_stb = 1'b0, max_rt_stb = 1'b0;
  logic [7:0] rx_push_data = '0;
  logic [7:0] tx_head;
  logic tx_empty, irq_n, feat_en;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] got_q[$];

  always #4 clk = ~clk;

  rspi_cmd_decoder u_dut (
    .clk, .rst_n, .spi_csn, .spi_sck, .spi_mosi, .spi_miso,
    .rx_push, .rx_push_data, .rx_pkt_stb, .tx_pop, .tx_head, .tx_empty,
    .tx_sent_stb, .max_rt_stb, .irq_n, .feat_en
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: pairs each captured byte with its expectation
  always @(negedge clk) begin
    while (got_q.size() > 0 && exp_q.size() > 0) begin
      logic [7:0] g, e;
      string t;
      g = got_q.pop_front();
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(g === e, t, g, e);
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(input logic [7:0] mo, input int nbits, output logic [7:0] mi);
    mi = '0;
    for (int i = 7; i >= 8 - nbits; i--) begin
      spi_mosi = mo[i];
      wait_clk(HALF);
      mi[i] = spi_miso;
      spi_sck = 1'b1;
      wait_clk(HALF);
      spi_sck = 1'b0;
    end
  endtask

  task automatic cs_lo();
    spi_csn = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic cs_hi();
    wait_clk(HALF);
    spi_csn = 1'b1;
    wait_clk(HALF);
  endtask

  // Driver: the expected value goes into the scoreboard before the byte moves
  task automatic xchk(input logic [7:0] mo, input logic [7:0] exp, input string tag);
    logic [7:0] mi;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    shift_bits(mo, 8, mi);
    got_q.push_back(mi);
  endtask

  task automatic xany(input logic [7:0] mo);
    logic [7:0] mi;
    shift_bits(mo, 8, mi);
  endtask

  task automatic cmd1(input logic [7:0] c);
    cs_lo(); xany(c); cs_hi();
  endtask

  task automatic cmd2(input logic [7:0] c, input logic [7:0] d);
    cs_lo(); xany(c); xany(d); cs_hi();
  endtask

  task automatic read_reg(input logic [4:0] a, input logic [7:0] exp, input string tag);
    cs_lo(); xany({3'b000, a}); xchk(8'hFF, exp, tag); cs_hi();
  endtask

  task automatic read_status(input logic [7:0] exp, input string tag);
    cs_lo(); xchk(8'hFF, exp, tag); cs_hi();
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1; wait_clk(1); s = 1'b0; wait_clk(1);
  endtask

  task automatic push_rx(input logic [7:0] d);
    rx_push_data = d; rx_push = 1'b1; wait_clk(1); rx_push = 1'b0; wait_clk(1);
  endtask

  task automatic pop_tx_chk(input logic [7:0] exp, input string tag);
    check(tx_empty === 1'b0 && tx_head === exp, tag, tx_head, exp);
    tx_pop = 1'b1; wait_clk(1); tx_pop = 1'b0; wait_clk(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] mi;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);

    // Reset state
    check(irq_n === 1'b1, "R12 reset irq_n", irq_n, 1);
    check(tx_empty === 1'b1, "R6 reset tx_empty", tx_empty, 1);
    check(feat_en === 1'b0, "R10 reset feat_en", feat_en, 0);
    read_status(8'h0E, "R1 status after reset");

    // Register write/read and burst wrap
    cmd2(8'h25, 8'h4C);
    cs_lo(); xchk(8'h05, 8'h0E, "R1 status on read cmd"); xchk(8'hFF, 8'h4C, "R2 read reg5"); cs_hi();
    cs_lo(); xany(8'h3F); xany(8'hAA); xany(8'hBB); cs_hi();
    cs_lo(); xany(8'h1F); xchk(8'hFF, 8'hAA, "R2 reg31"); xchk(8'hFF, 8'hBB, "R2 wrap reg0"); cs_hi();

    // Flags and write-one-to-clear
    pulse(rx_pkt_stb); pulse(tx_sent_stb); pulse(max_rt_stb);
    check(irq_n === 1'b0, "R12 irq_n with flags", irq_n, 0);
    read_status(8'h7E, "R1 all flags");
    cmd2(8'h27, 8'h20);
    read_status(8'h5E, "R3 clear only data-sent");
    read_reg(5'h07, 8'h5E, "R1 status via address 7");
    cmd2(8'h27, 8'h50);
    read_status(8'h0E, "R3 clear remaining");
    check(irq_n === 1'b1, "R12 irq_n released", irq_n, 1);

    // Queue status register and its write protection
    read_reg(5'h17, 8'h11, "R4 both empty");
    cmd2(8'h37, 8'hFF);
    read_reg(5'h17, 8'h11, "R4 write ignored");

    // Receive unload, width, empty read
    push_rx(8'h11); push_rx(8'h22); push_rx(8'h33); push_rx(8'h44);
    read_status(8'h00, "R1 pipe 0 when data");
    cs_lo(); xany(8'h60); xchk(8'hFF, 8'h04, "R9 width nonempty"); cs_hi();
    cs_lo(); xchk(8'h61, 8'h00, "R1 status on unload");
    xchk(8'hFF, 8'h11, "R5 b0"); xchk(8'hFF, 8'h22, "R5 b1");
    xchk(8'hFF, 8'h33, "R5 b2"); xchk(8'hFF, 8'h44, "R5 b3");
    xchk(8'hFF, 8'h00, "R5 past end"); cs_hi();
    read_reg(5'h17, 8'h11, "R5 empty after unload");
    cs_lo(); xany(8'h60); xchk(8'hFF, 8'h00, "R9 width empty"); cs_hi();
    cs_lo(); xany(8'h61); xchk(8'hFF, 8'h00, "R5 empty read"); xchk(8'hFF, 8'h00, "R5 empty read 2"); cs_hi();
    read_reg(5'h17, 8'h11, "R5 state unchanged");

    // Receive overflow
    for (int i = 0; i < 9; i++) push_rx(8'h80 + 8'(i));
    read_reg(5'h17, 8'h12, "R4 rx full");
    cs_lo(); xany(8'h61);
    for (int i = 0; i < 8; i++) xchk(8'hFF, 8'h80 + 8'(i), "R5 overflow order");
    xchk(8'hFF, 8'h00, "R5 ninth dropped"); cs_hi();

    // Receive flush
    push_rx(8'h5A); push_rx(8'h5B);
    cmd1(8'hE2);
    read_reg(5'h17, 8'h11, "R7 rx flushed");

    // Transmit load, ack payload, flush, overflow
    cs_lo(); xany(8'hA0); xany(8'h01); xany(8'h02); xany(8'h03); cs_hi();
    pop_tx_chk(8'h01, "R6 tx b0"); pop_tx_chk(8'h02, "R6 tx b1"); pop_tx_chk(8'h03, "R6 tx b2");
    check(tx_empty === 1'b1, "R6 tx drained", tx_empty, 1);
    cmd2(8'hAB, 8'h09);
    check(tx_empty === 1'b0 && tx_head === 8'h09, "R6 ack payload", tx_head, 8'h09);
    cmd1(8'hE1);
    check(tx_empty === 1'b1, "R7 tx flushed", tx_empty, 1);
    cs_lo(); xany(8'hA0);
    for (int i = 0; i < 9; i++) xany(8'h40 + 8'(i));
    cs_hi();
    read_status(8'h0F, "R1 tx full bit");
    read_reg(5'h17, 8'h21, "R4 tx full");
    for (int i = 0; i < 8; i++) pop_tx_chk(8'h40 + 8'(i), "R6 overflow order");
    check(tx_empty === 1'b1, "R6 ninth dropped", tx_empty, 1);

    // Reuse marker
    cmd1(8'hE3);
    read_reg(5'h17, 8'h51, "R8 reuse set");
    cmd1(8'hE1);
    read_reg(5'h17, 8'h11, "R8 cleared by tx flush");
    cmd1(8'hE3);
    cmd2(8'hA0, 8'h05);
    read_reg(5'h17, 8'h01, "R8 cleared by tx load");
    cmd1(8'hE1);

    // Activate
    cmd2(8'h50, 8'h12);
    check(feat_en === 1'b0, "R10 wrong key", feat_en, 0);
    cmd2(8'h50, 8'h73);
    check(feat_en === 1'b1, "R10 key toggles on", feat_en, 1);
    cmd2(8'h50, 8'h73);
    check(feat_en === 1'b0, "R10 key toggles off", feat_en, 0);

    // Chip select ends a byte early
    cmd2(8'h2A, 8'h3C);
    cs_lo(); xany(8'h2A); shift_bits(8'hFF, 4, mi); cs_hi();
    read_reg(5'h0A, 8'h3C, "R11 partial write discarded");
    cs_lo(); shift_bits(8'hE2, 5, mi); cs_hi();
    read_status(8'h0E, "R11 partial command inert");

    wait_clk(4);
    check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule